// File: doc/BRIEF.md
# Multiplexed-Bus Slave Interface and Window Decoder

This block sits between a host that shares one 8-bit path for the low address byte and for data, and the storage behind it: a small register file and a byte-wide nonvolatile array. All bus pins are sampled by a faster system clock, and the strobe edges are found synchronously. When the address strobe falls, the block latches the 16-bit address. It then compares the address against two windows whose base addresses come from two map registers: a 1 KB register window and an 8 KB memory window. While the data clock is high it raises one of two select lines, one for the register window and one for the memory window. When the data clock falls during a write, it issues a one-cycle write strobe together with the captured data byte.

Reads are steered onto a separate output byte with its own enable. That byte carries the complemented contents of either map register when the host addresses one of them. Otherwise it carries the register or memory read data supplied from outside the block. A fixed set of register slots and a 16-byte scratch area inside the register window are decoded one-hot for the register file. A mode bit in the memory map register turns the auxiliary 8-bit port into a copy of the latched low address byte. A second bit in that register sets the polarity of an external reset pin.

Top module: `mbus_if`

## Requirements
- R1: When the address strobe is first sampled low after being sampled high (sample edge t), `acc_addr` shows the high byte and low byte sampled at edge t from edge t+1 onward. It holds that value until the next such falling edge.
- R2: An access is qualified only if, at the sample where the strobe is first seen low, `bus_ce` is 1 and `bus_sel_n` is 0. An unqualified access raises no select, no slot, no write strobe and no read drive.
- R3: The register window matches when address bits 15:10 equal bits 5:0 of the register map. The register map resets to 0x81, so the window starts at 0x0400.
- R4: The memory window matches when address bits 15:13 equal bits 2:0 of the memory map. The memory map resets to 0x07, so the window starts at 0xE000. `mem_off` is address bits 12:0 and `reg_off` is address bits 9:0.
- R5: If both windows match, only the register window is selected.
- R6: `reg_sel` and `mem_sel` are high only during cycles in which the data clock was sampled high, for a qualified access to their window.
- R7: For a qualified access with read/write sampled low, the cycle after the data clock is first sampled low carries a single-cycle `wr_reg_stb` or `wr_mem_stb`. `wr_data` then holds the low byte sampled when the data clock was first seen low.
- R8: `bus_ad_oe` is 1 only for a qualified access while the data clock and read/write are both sampled high. When it is 0, `bus_ad_out` is 0.
- R9: A read at register offset 0x000 returns the bitwise complement of the register map. A read at offset 0x038 returns the bitwise complement of the memory map.
- R10: Any other register-window read returns `reg_rdata`, and a memory-window read returns `mem_rdata`.
- R11: While `reg_sel` is high, offsets 0x000 to 0x038 in steps of 8 raise `reg_slot` bit (offset>>3). Offsets 0x200 to 0x20F raise bit 8. Every other offset raises no bit.
- R12: With memory-map bit 5 set, `pb_out` equals `acc_addr[7:0]` and `lam_on` is 1. With it clear, `pb_out` follows `pb_gpio`.
- R13: `periph_rst` equals `rst_pin` when memory-map bit 3 is 1, and equals the inverse of `rst_pin` when that bit is 0.
- R14: A map write strobe loads `cfg_wdata` at that clock edge. A decode latched at the same edge still compares against the previous map value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_as | input | 1 | Address strobe, latches on falling edge |
| bus_e | input | 1 | Data clock, transfers while high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_ce | input | 1 | Active-high chip enable |
| bus_sel_n | input | 1 | Active-low device select |
| bus_ahi | input | 8 | Address bits 15:8 |
| bus_ad_in | input | 8 | Multiplexed low address / write data |
| bus_ad_out | output | 8 | Read data toward the host |
| bus_ad_oe | output | 1 | Read data drive enable |
| cfg_wr_regmap | input | 1 | Load register map |
| cfg_wr_memmap | input | 1 | Load memory map |
| cfg_wdata | input | 8 | Map load value |
| reg_rdata | input | 8 | Register file read data |
| mem_rdata | input | 8 | Memory array read data |
| reg_sel | output | 1 | Register window selected, data phase |
| mem_sel | output | 1 | Memory window selected, data phase |
| reg_slot | output | 9 | One-hot register slot / scratch select |
| reg_off | output | 10 | Offset within register window |
| mem_off | output | 13 | Offset within memory window |
| acc_addr | output | 16 | Latched address |
| wr_reg_stb | output | 1 | Register write strobe |
| wr_mem_stb | output | 1 | Memory write strobe |
| wr_data | output | 8 | Captured write data |
| pb_gpio | input | 8 | Auxiliary port value in normal mode |
| pb_out | output | 8 | Auxiliary port output |
| lam_on | output | 1 | Address-output mode active |
| rst_pin | input | 1 | External reset pin |
| periph_rst | output | 1 | Reset request, active high |

## Verification
A map register load can land on the same clock edge at which the decoder latches a new access. The bench provokes this by pulsing the memory-map load one sample after the strobe is first seen low, which moves the memory window away from the address being accessed. The result must show the access still hitting the old window, with the new window taking effect only for the following access. The behavioural model applies the load after evaluating the decode at each edge and compares all outputs on every clock, so a design that decodes against the new value shows a select mismatch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef struct packed {
    logic reg_hit;
    logic mem_hit;
  } win_hit_t;

  localparam int unsigned SLOT_REGMAP = 0;
  localparam int unsigned SLOT_MEMMAP = 7;
endpackage

// File: rtl/mbus_sampler.sv
module mbus_sampler #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_as,
  input  logic          bus_e,
  input  logic          bus_rw,
  input  logic          bus_ce,
  input  logic          bus_sel_n,
  input  logic [AW-DW-1:0] bus_ahi,
  input  logic [DW-1:0] bus_ad_in,
  output logic          as_fall,
  output logic          e_fall,
  output logic          e_hi,
  output logic          rw_hi,
  output logic          cs_ok,
  output logic [AW-1:0] addr_smp,
  output logic [DW-1:0] ad_smp
);
  localparam int unsigned HW = AW - DW;

  logic          as_q, as_d, e_q, e_d, rw_q, ce_q, seln_q;
  logic [HW-1:0] ahi_q;
  logic [DW-1:0] ad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q   <= 1'b1;
      as_d   <= 1'b1;
      e_q    <= 1'b0;
      e_d    <= 1'b0;
      rw_q   <= 1'b1;
      ce_q   <= 1'b0;
      seln_q <= 1'b1;
      ahi_q  <= '0;
      ad_q   <= '0;
    end else begin
      as_q   <= bus_as;
      as_d   <= as_q;
      e_q    <= bus_e;
      e_d    <= e_q;
      rw_q   <= bus_rw;
      ce_q   <= bus_ce;
      seln_q <= bus_sel_n;
      ahi_q  <= bus_ahi;
      ad_q   <= bus_ad_in;
    end
  end

  assign as_fall  = as_d & ~as_q;
  assign e_fall   = e_d & ~e_q;
  assign e_hi     = e_q;
  assign rw_hi    = rw_q;
  assign cs_ok    = ce_q & ~seln_q;
  assign addr_smp = {ahi_q, ad_q};
  assign ad_smp   = ad_q;
endmodule

// File: rtl/mbus_decode.sv
module mbus_decode import mbus_pkg::*; #(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned REG_WIN_LG = 10,
  parameter int unsigned MEM_WIN_LG = 13,
  parameter logic [7:0]  REGMAP_RST = 8'h81,
  parameter logic [7:0]  MEMMAP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_fall,
  input  logic          cs_ok,
  input  logic [AW-1:0] addr_smp,
  input  logic          cfg_wr_regmap,
  input  logic          cfg_wr_memmap,
  input  logic [DW-1:0] cfg_wdata,
  output logic [AW-1:0] addr_lat,
  output win_hit_t      hit,
  output logic [DW-1:0] regmap,
  output logic [DW-1:0] memmap
);
  localparam int unsigned RTAG = AW - REG_WIN_LG;
  localparam int unsigned MTAG = AW - MEM_WIN_LG;

  logic [AW-1:0] addr_q, addr_n;
  win_hit_t      hit_q, hit_n;
  logic [DW-1:0] regmap_q, regmap_n, memmap_q, memmap_n;
  logic          raw_reg, raw_mem;

  always_comb begin
    raw_reg = (addr_smp[AW-1:REG_WIN_LG] == regmap_q[RTAG-1:0]);
    raw_mem = (addr_smp[AW-1:MEM_WIN_LG] == memmap_q[MTAG-1:0]);
    addr_n  = addr_q;
    hit_n   = hit_q;
    if (as_fall) begin
      addr_n        = addr_smp;
      hit_n.reg_hit = cs_ok & raw_reg;
      hit_n.mem_hit = cs_ok & raw_mem & ~raw_reg;
    end
    regmap_n = cfg_wr_regmap ? cfg_wdata : regmap_q;
    memmap_n = cfg_wr_memmap ? cfg_wdata : memmap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      hit_q    <= '0;
      regmap_q <= REGMAP_RST;
      memmap_q <= MEMMAP_RST;
    end else begin
      addr_q   <= addr_n;
      hit_q    <= hit_n;
      regmap_q <= regmap_n;
      memmap_q <= memmap_n;
    end
  end

  assign addr_lat = addr_q;
  assign hit      = hit_q;
  assign regmap   = regmap_q;
  assign memmap   = memmap_q;

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(as_fall) |-> $stable(addr_lat));

  assert_map_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr_memmap) |-> $stable(memmap));
endmodule

// File: rtl/mbus_rdmux.sv
module mbus_rdmux import mbus_pkg::*; #(
  parameter int unsigned DW         = 8,
  parameter int unsigned REG_WIN_LG = 10,
  parameter int unsigned SLOT_LG    = 3,
  parameter int unsigned SLOTS      = 8,
  parameter int unsigned SCR_BASE   = 'h200,
  parameter int unsigned SCR_LG     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  win_hit_t              hit,
  input  logic                  e_hi,
  input  logic                  rw_hi,
  input  logic [REG_WIN_LG-1:0] reg_off,
  input  logic [DW-1:0]         regmap,
  input  logic [DW-1:0]         memmap,
  input  logic [DW-1:0]         reg_rdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  reg_sel,
  output logic                  mem_sel,
  output logic [DW-1:0]         ad_out,
  output logic                  ad_oe,
  output logic [SLOTS:0]        reg_slot
);
  localparam int unsigned SLOT_W   = $clog2(SLOTS);
  localparam int unsigned SLOT_TOP = SLOT_LG + SLOT_W;
  localparam logic [REG_WIN_LG-1:0] SCR_VEC = REG_WIN_LG'(SCR_BASE);

  logic on_grid, in_scr;

  assign reg_sel = hit.reg_hit & e_hi;
  assign mem_sel = hit.mem_hit & e_hi;
  assign on_grid = (reg_off[REG_WIN_LG-1:SLOT_TOP] == '0) &&
                   (reg_off[SLOT_LG-1:0] == '0);
  assign in_scr  = (reg_off[REG_WIN_LG-1:SCR_LG] == SCR_VEC[REG_WIN_LG-1:SCR_LG]);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign reg_slot[g] = reg_sel & on_grid &
                         (reg_off[SLOT_TOP-1:SLOT_LG] == SLOT_W'(g));
  end
  assign reg_slot[SLOTS] = reg_sel & in_scr;

  always_comb begin
    ad_oe  = (hit.reg_hit | hit.mem_hit) & e_hi & rw_hi;
    ad_out = '0;
    if (ad_oe) begin
      if (hit.reg_hit) begin
        if (reg_slot[SLOT_REGMAP])      ad_out = ~regmap;
        else if (reg_slot[SLOT_MEMMAP]) ad_out = ~memmap;
        else                            ad_out = reg_rdata;
      end else begin
        ad_out = mem_rdata;
      end
    end
  end

  assert_slot_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_slot));

  assert_window_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_sel, mem_sel}));
endmodule

// File: rtl/mbus_if.sv
module mbus_if import mbus_pkg::*; #(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 16,
  parameter int unsigned REG_WIN_LG = 10,
  parameter int unsigned MEM_WIN_LG = 13,
  parameter int unsigned SLOTS      = 8,
  parameter int unsigned RST_BIT    = 3,
  parameter int unsigned LAM_BIT    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_as,
  input  logic                  bus_e,
  input  logic                  bus_rw,
  input  logic                  bus_ce,
  input  logic                  bus_sel_n,
  input  logic [AW-DW-1:0]      bus_ahi,
  input  logic [DW-1:0]         bus_ad_in,
  output logic [DW-1:0]         bus_ad_out,
  output logic                  bus_ad_oe,
  input  logic                  cfg_wr_regmap,
  input  logic                  cfg_wr_memmap,
  input  logic [DW-1:0]         cfg_wdata,
  input  logic [DW-1:0]         reg_rdata,
  input  logic [DW-1:0]         mem_rdata,
  output logic                  reg_sel,
  output logic                  mem_sel,
  output logic [SLOTS:0]        reg_slot,
  output logic [REG_WIN_LG-1:0] reg_off,
  output logic [MEM_WIN_LG-1:0] mem_off,
  output logic [AW-1:0]         acc_addr,
  output logic                  wr_reg_stb,
  output logic                  wr_mem_stb,
  output logic [DW-1:0]         wr_data,
  input  logic [DW-1:0]         pb_gpio,
  output logic [DW-1:0]         pb_out,
  output logic                  lam_on,
  input  logic                  rst_pin,
  output logic                  periph_rst
);
  logic          as_fall, e_fall, e_hi, rw_hi, cs_ok;
  logic [AW-1:0] addr_smp, addr_lat;
  logic [DW-1:0] ad_smp, regmap, memmap;
  win_hit_t      hit;

  mbus_sampler #(.DW(DW), .AW(AW)) u_smp (
    .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_e(bus_e), .bus_rw(bus_rw),
    .bus_ce(bus_ce), .bus_sel_n(bus_sel_n), .bus_ahi(bus_ahi), .bus_ad_in(bus_ad_in),
    .as_fall(as_fall), .e_fall(e_fall), .e_hi(e_hi), .rw_hi(rw_hi), .cs_ok(cs_ok),
    .addr_smp(addr_smp), .ad_smp(ad_smp));

  mbus_decode #(.AW(AW), .DW(DW), .REG_WIN_LG(REG_WIN_LG), .MEM_WIN_LG(MEM_WIN_LG)) u_dec (
    .clk(clk), .rst_n(rst_n), .as_fall(as_fall), .cs_ok(cs_ok), .addr_smp(addr_smp),
    .cfg_wr_regmap(cfg_wr_regmap), .cfg_wr_memmap(cfg_wr_memmap), .cfg_wdata(cfg_wdata),
    .addr_lat(addr_lat), .hit(hit), .regmap(regmap), .memmap(memmap));

  mbus_rdmux #(.DW(DW), .REG_WIN_LG(REG_WIN_LG), .SLOTS(SLOTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .hit(hit), .e_hi(e_hi), .rw_hi(rw_hi),
    .reg_off(addr_lat[REG_WIN_LG-1:0]), .regmap(regmap), .memmap(memmap),
    .reg_rdata(reg_rdata), .mem_rdata(mem_rdata), .reg_sel(reg_sel), .mem_sel(mem_sel),
    .ad_out(bus_ad_out), .ad_oe(bus_ad_oe), .reg_slot(reg_slot));

  // write strobe stage
  logic          wfire;
  logic          wreg_q, wreg_n, wmem_q, wmem_n;
  logic [DW-1:0] wdat_q, wdat_n;

  always_comb begin
    wfire  = e_fall & (hit.reg_hit | hit.mem_hit) & ~rw_hi;
    wreg_n = wfire & hit.reg_hit;
    wmem_n = wfire & hit.mem_hit;
    wdat_n = wfire ? ad_smp : wdat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wreg_q <= 1'b0;
      wmem_q <= 1'b0;
      wdat_q <= '0;
    end else begin
      wreg_q <= wreg_n;
      wmem_q <= wmem_n;
      wdat_q <= wdat_n;
    end
  end

  assign wr_reg_stb = wreg_q;
  assign wr_mem_stb = wmem_q;
  assign wr_data    = wdat_q;
  assign acc_addr   = addr_lat;
  assign reg_off    = addr_lat[REG_WIN_LG-1:0];
  assign mem_off    = addr_lat[MEM_WIN_LG-1:0];
  assign lam_on     = memmap[LAM_BIT];
  assign pb_out     = lam_on ? addr_lat[DW-1:0] : pb_gpio;
  assign periph_rst = memmap[RST_BIT] ? rst_pin : ~rst_pin;

  assert_wstb_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reg_stb | wr_mem_stb) |=> !(wr_reg_stb | wr_mem_stb));
endmodule

// File: tb/sim_mbus_if.sv
module sim_mbus_if;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_as, bus_e, bus_rw, bus_ce, bus_sel_n;
  logic [7:0] bus_ahi, bus_ad_in, bus_ad_out;
  logic bus_ad_oe;
  logic cfg_wr_regmap, cfg_wr_memmap;
  logic [7:0] cfg_wdata, reg_rdata, mem_rdata;
  logic reg_sel, mem_sel;
  logic [8:0] reg_slot;
  logic [9:0] reg_off;
  logic [12:0] mem_off;
  logic [15:0] acc_addr;
  logic wr_reg_stb, wr_mem_stb;
  logic [7:0] wr_data, pb_gpio, pb_out;
  logic lam_on, rst_pin, periph_rst;

  always #2 clk = ~clk;

  mbus_if u0 (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  string phase = "R1";

  // behavioural model state
  logic m_as_q, m_as_d, m_e_q, m_e_d, m_rw_q, m_ce_q, m_seln_q;
  logic [15:0] m_addr_q, m_addr;
  logic m_rh, m_mh, m_wreg, m_wmem;
  logic [7:0] m_wdata, m_regmap, m_memmap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_as_q = 1; m_as_d = 1; m_e_q = 0; m_e_d = 0; m_rw_q = 1; m_ce_q = 0; m_seln_q = 1;
      m_addr_q = 0; m_addr = 0; m_rh = 0; m_mh = 0; m_wreg = 0; m_wmem = 0; m_wdata = 0;
      m_regmap = 8'h81; m_memmap = 8'h07;
    end else begin
      bit fire, cs, rh, mh;
      fire = m_e_d && !m_e_q && (m_rh || m_mh) && !m_rw_q;
      m_wreg = fire && m_rh;
      m_wmem = fire && m_mh;
      if (fire) m_wdata = m_addr_q[7:0];
      if (m_as_d && !m_as_q) begin
        cs = m_ce_q && !m_seln_q;
        rh = (m_addr_q[15:10] == m_regmap[5:0]);
        mh = !rh && (m_addr_q[15:13] == m_memmap[2:0]);
        m_rh = cs && rh;
        m_mh = cs && mh;
        m_addr = m_addr_q;
      end
      if (cfg_wr_regmap) m_regmap = cfg_wdata;
      if (cfg_wr_memmap) m_memmap = cfg_wdata;
      m_as_d = m_as_q; m_as_q = bus_as;
      m_e_d = m_e_q; m_e_q = bus_e;
      m_rw_q = bus_rw; m_ce_q = bus_ce; m_seln_q = bus_sel_n;
      m_addr_q = {bus_ahi, bus_ad_in};
    end
  end

  task automatic cmp(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (phase %s) at %0t: actual %h expected %h", req, phase, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic oe, rsel, msel;
      logic [7:0] eout;
      logic [8:0] eslot;
      logic [9:0] off;
      off  = m_addr[9:0];
      rsel = m_rh && m_e_q;
      msel = m_mh && m_e_q;
      oe   = (m_rh || m_mh) && m_e_q && m_rw_q;
      eslot = '0;
      if (rsel) begin
        if (off[9:6] == 0 && off[2:0] == 0) eslot[off[5:3]] = 1'b1;
        else if (off[9:4] == 6'h20) eslot[8] = 1'b1;
      end
      eout = 8'h00;
      if (oe) begin
        if (!m_rh) eout = mem_rdata;
        else if (rsel && off == 10'h000) eout = ~m_regmap;
        else if (rsel && off == 10'h038) eout = ~m_memmap;
        else eout = reg_rdata;
      end
      cmp("R1 acc_addr", acc_addr, m_addr);
      cmp("R3 reg_sel", {15'd0, reg_sel}, {15'd0, rsel});
      cmp("R4 mem_sel", {15'd0, mem_sel}, {15'd0, msel});
      cmp("R4 mem_off", {3'd0, mem_off}, {3'd0, m_addr[12:0]});
      cmp("R11 reg_slot", {7'd0, reg_slot}, {7'd0, eslot});
      cmp("R8 ad_oe", {15'd0, bus_ad_oe}, {15'd0, oe});
      cmp("R9 R10 ad_out", {8'd0, bus_ad_out}, {8'd0, eout});
      cmp("R7 wr strobes", {14'd0, wr_reg_stb, wr_mem_stb}, {14'd0, m_wreg, m_wmem});
      cmp("R7 wr_data", {8'd0, wr_data}, {8'd0, m_wdata});
      cmp("R12 pb_out", {7'd0, lam_on, pb_out},
          {7'd0, m_memmap[5], (m_memmap[5] ? m_addr[7:0] : pb_gpio)});
      cmp("R13 periph_rst", {15'd0, periph_rst},
          {15'd0, (m_memmap[3] ? rst_pin : !rst_pin)});
    end
  end

  task automatic bus_cyc(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                         input logic ce, input logic seln,
                         input logic cfg_at_latch, input logic [7:0] cfg_val);
    @(negedge clk);
    bus_as = 1; bus_e = 0; bus_ahi = a[15:8]; bus_ad_in = a[7:0];
    bus_rw = rw; bus_ce = ce; bus_sel_n = seln;
    repeat (2) @(negedge clk);
    bus_as = 0;
    @(negedge clk);
    if (cfg_at_latch) begin cfg_wr_memmap = 1; cfg_wdata = cfg_val; end
    @(negedge clk);
    cfg_wr_memmap = 0;
    @(negedge clk);
    if (!rw) bus_ad_in = wd;
    bus_e = 1;
    repeat (4) @(negedge clk);
    bus_e = 0;
    repeat (2) @(negedge clk);
    bus_as = 1; bus_ce = 0; bus_sel_n = 1; bus_rw = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a);
    bus_cyc(a, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_cyc(a, 1'b0, d, 1'b1, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic load_map(input bit which_mem, input logic [7:0] v);
    @(negedge clk);
    cfg_wdata = v;
    if (which_mem) cfg_wr_memmap = 1; else cfg_wr_regmap = 1;
    @(negedge clk);
    cfg_wr_memmap = 0; cfg_wr_regmap = 0;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired in phase %s", phase);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_as = 1; bus_e = 0; bus_rw = 1; bus_ce = 0; bus_sel_n = 1;
    bus_ahi = 0; bus_ad_in = 0; cfg_wr_regmap = 0; cfg_wr_memmap = 0; cfg_wdata = 0;
    reg_rdata = 8'h3C; mem_rdata = 8'hA5; pb_gpio = 8'h96; rst_pin = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    repeat (3) @(negedge clk);
    // reset state with default map values
    phase = "R9";  rd(16'h0400); rd(16'h0438);
    phase = "R11"; rd(16'h0410); rd(16'h0428); rd(16'h0605); rd(16'h060F); rd(16'h0404); rd(16'h0610);
    phase = "R10"; reg_rdata = 8'h71; rd(16'h0430); mem_rdata = 8'h1E; rd(16'hE123);
    phase = "R7";  wr(16'hFFFF, 8'h5A); wr(16'h0420, 8'hC3); wr(16'hE000, 8'h00);
    phase = "R2";
    bus_cyc(16'h0400, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    bus_cyc(16'hE010, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00);
    bus_cyc(16'hE020, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0, 8'h00);
    phase = "R3";  rd(16'h3000); rd(16'h0800);
    phase = "R5";  load_map(1'b0, 8'hB8); rd(16'hE000); rd(16'hE438); rd(16'hE800); wr(16'hE008, 8'h99);
    phase = "R13"; rst_pin = 0; repeat (2) @(negedge clk); rst_pin = 1;
    phase = "R12"; load_map(1'b1, 8'h2A); rd(16'h4133); pb_gpio = 8'h5C; rd(16'h40FE);
    phase = "R13"; rst_pin = 0; repeat (2) @(negedge clk); rst_pin = 1; @(negedge clk);
    phase = "R14";
    bus_cyc(16'h4177, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h07);
    rd(16'h4177); rd(16'hE200);
    phase = "R6";  mem_rdata = 8'h00; rd(16'hE3FF);
    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule